// File: doc/BRIEF.md
# Output Clock Divider with Phase Select

This block divides the fast distribution clock down to a slower output clock. The ratio can be any integer from 1 to 32. A bypass flag sends the fast clock straight to the output. Each instance also holds a starting-phase setting. Several instances that receive the same sync request all restart on the same fast-clock edge, and each one's count begins at its own phase. The outputs therefore keep a chosen whole-cycle skew between them.

A sync request counts only when the active-low sync input is seen low at three half-cycle samples in a row: two consecutive rising edges and the falling edge between them. Shorter low pulses are ignored. The controlling state machine has two states:

- **ST_RUN**: counting.
- **ST_HOLD**: the counter is frozen and the divided output is held low.

It moves from ST_RUN to ST_HOLD on a qualified sync. It returns from ST_HOLD to ST_RUN on the first rising edge at which sync is seen high again. On that return the divide and phase settings are loaded. At any other time a new divide setting is taken only at the end of a full output period.

Top module: `clkdiv_phase`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low. After release, the divider starts at ratio 1 and adopts `div_sel` at the first rising edge.
- R2: While `bypass` is 1, `clk_out` equals `clk`, whatever the other settings are.
- R3: `div_sel` holds the ratio minus one. The value 31 gives divide by 32. The value 0 gives divide by 1, and `clk_out` then equals `clk`.
- R4: For a ratio R of 2 or more, the output period is R fast cycles. The output goes high at count 0 and stays high for floor(R/2) cycles. It is low for the remaining cycles, so odd ratios have the longer low phase.
- R5: A sync request is qualified only if `sync_n` is low at two consecutive rising edges and at the falling edge between them. A low pulse covering fewer of these samples has no effect on `clk_out`.
- R6: From the rising edge at which a sync request is qualified, the divided output is low and the count is frozen. This lasts as long as `sync_n` stays low.
- R7: At the first rising edge in ST_HOLD with `sync_n` high, the ratio is reloaded from `div_sel` and the count is loaded with `phase_sel`. The output then matches a divider that had run `phase_sel` cycles past a period start.
- R8: If `phase_sel` is not below the ratio, the loaded count is clamped to ratio minus one.
- R9: Outside a sync release, a change of `div_sel` takes effect only after the current output period completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast distribution clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Sync request, active low |
| bypass | input | 1 | Pass the fast clock straight to the output |
| div_sel | input | CNT_W | Divide ratio minus one |
| phase_sel | input | CNT_W | Starting count loaded on sync release |
| clk_out | output | 1 | Divided (or passed) clock |

## Verification
The hardest situations to reach are the near-miss sync pulses. These are a low level that covers one rising and one falling sample, in either order, but not the full three-sample window. The bench reaches them by moving the sync input at a quarter period after either clock edge. This gives half-cycle control over which samples see the low level.

A reference model is updated on both edges and compared with `clk_out` in the high and low half of every cycle. Because it runs on every edge, an off-by-one in the window, the clamp or the reload boundary shows up as a mismatch.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } cdiv_state_e;
endpackage

// File: rtl/cdiv_sync_qual.sv
module cdiv_sync_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    output logic low_now,
    output logic qual
);
    logic fall_low;
    logic rise_low;

    // low level seen at the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_low <= 1'b0;
        else        fall_low <= ~sync_n;
    end

    // low level seen at the previous rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_low <= 1'b0;
        else        rise_low <= ~sync_n;
    end

    assign low_now = ~sync_n;
    // rising, falling, rising: three half-cycle samples in a row
    assign qual    = low_now & fall_low & rise_low;
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
    import cdiv_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual,
    input  logic             low_now,
    input  logic [CNT_W-1:0] div_sel,
    input  logic [CNT_W-1:0] phase_sel,
    output logic             out_q,
    output logic             div_one,
    output cdiv_state_e      st_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] act_q
);
    localparam int RW = CNT_W + 1;
    localparam logic [RW-1:0]    RONE = RW'(1);
    localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

    cdiv_state_e      st_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] act_nxt;
    logic [CNT_W-1:0] ph_clamped;
    logic [RW-1:0]    ratio_nxt;
    logic [RW-1:0]    half_nxt;
    logic             force_low;
    logic             at_tc;
    logic             out_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_RUN:  st_nxt = qual    ? ST_HOLD : ST_RUN;
            ST_HOLD: st_nxt = low_now ? ST_HOLD : ST_RUN;
        endcase
    end

    // count, ratio and output next values
    always_comb begin
        at_tc      = (cnt_q == act_q);
        ph_clamped = (phase_sel > div_sel) ? div_sel : phase_sel;
        cnt_nxt    = cnt_q;
        act_nxt    = act_q;
        force_low  = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (qual) begin
                    force_low = 1'b1;
                end else if (at_tc) begin
                    cnt_nxt = '0;
                    act_nxt = div_sel;
                end else begin
                    cnt_nxt = cnt_q + CONE;
                end
            end
            ST_HOLD: begin
                if (low_now) begin
                    force_low = 1'b1;
                end else begin
                    cnt_nxt = ph_clamped;
                    act_nxt = div_sel;
                end
            end
        endcase
        ratio_nxt = {1'b0, act_nxt} + RONE;
        half_nxt  = ratio_nxt >> 1;
        out_nxt   = !force_low && ({1'b0, cnt_nxt} < half_nxt);
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            act_q <= act_nxt;
            out_q <= out_nxt;
        end
    end

    assign div_one = (act_q == '0);
endmodule

// File: rtl/cdiv_out_sel.sv
module cdiv_out_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic pass,
    input  logic div_clk,
    output logic clk_out
);
    assign clk_out = rst_n & (pass ? clk : div_clk);
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
    import cdiv_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n,
    input  logic             bypass,
    input  logic [CNT_W-1:0] div_sel,
    input  logic [CNT_W-1:0] phase_sel,
    output logic             clk_out
);
    logic             sync_qual;
    logic             sync_low;
    logic             div_q;
    logic             div_one;
    cdiv_state_e      core_st;
    logic [CNT_W-1:0] core_cnt;
    logic [CNT_W-1:0] core_act;

    cdiv_sync_qual u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_n  (sync_n),
        .low_now (sync_low),
        .qual    (sync_qual)
    );

    cdiv_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .qual      (sync_qual),
        .low_now   (sync_low),
        .div_sel   (div_sel),
        .phase_sel (phase_sel),
        .out_q     (div_q),
        .div_one   (div_one),
        .st_q      (core_st),
        .cnt_q     (core_cnt),
        .act_q     (core_act)
    );

    cdiv_out_sel u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .pass    (bypass | div_one),
        .div_clk (div_q),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/clkdiv_phase_chk.sv
module clkdiv_phase_chk
    import cdiv_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_n,
    input logic             bypass,
    input logic             clk_out,
    input logic             qual,
    input logic             out_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] act_q,
    input cdiv_state_e      st
);
    localparam logic [CNT_W:0] HALF_MAX = (CNT_W+1)'(1 << (CNT_W-1));
    localparam logic [CNT_W:0] RUN_ONE  = (CNT_W+1)'(1);

    logic [CNT_W:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               hi_run <= '0;
        else if (!out_q)          hi_run <= '0;
        else if (hi_run != '1)    hi_run <= hi_run + RUN_ONE;
    end

    always_comb begin
        if (!rst_n) AST_RESET_QUIET: assert (!clk_out); // R1
    end

    AST_BYPASS_FOLLOWS: assert property (@(negedge clk) disable iff (!rst_n)
        bypass |-> clk_out); // R2

    AST_HIGH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= HALF_MAX); // R4

    AST_SHORT_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && $past(sync_n)) |-> !qual); // R5

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> !out_q); // R6

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= act_q); // R8

    AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> (($past(cnt_q) == $past(act_q)) || ($past(st) == ST_HOLD))); // R9
endmodule

bind clkdiv_phase clkdiv_phase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_n  (sync_n),
    .bypass  (bypass),
    .clk_out (clk_out),
    .qual    (sync_qual),
    .out_q   (div_q),
    .cnt_q   (core_cnt),
    .act_q   (core_act),
    .st      (core_st)
);

// File: tb/tb_clkdiv_phase.sv
module tb_clkdiv_phase;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b1;
    logic       bypass = 1'b0;
    logic [4:0] div_sel = 5'd0;
    logic [4:0] phase_sel = 5'd0;
    logic       clk_out;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";

    // reference model state
    int m_div = 1;
    int m_cnt = 0;
    bit m_out = 0;
    bit m_hold = 0;
    bit m_prev = 0;
    bit m_neg = 0;

    clkdiv_phase dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_n    (sync_n),
        .bypass    (bypass),
        .div_sel   (div_sel),
        .phase_sel (phase_sel),
        .clk_out   (clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit exp);
        n_chk++;
        if (clk_out !== exp) begin
            n_err++;
            $display("FAIL %s: clk_out=%0b expected %0b at %0t", cur_req, clk_out, exp, $time);
        end
    endtask

    function automatic bit passing();
        return bypass || (m_div == 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 1; m_cnt = 0; m_out = 0; m_hold = 0; m_prev = 0;
        end else begin
            bit lo;
            bit q;
            lo = !sync_n;
            q  = lo && m_neg && m_prev;
            if (!m_hold) begin
                if (q) begin
                    m_hold = 1;
                    m_out  = 0;
                end else begin
                    if (m_cnt == m_div - 1) begin
                        m_cnt = 0;
                        m_div = int'(div_sel) + 1;
                    end else begin
                        m_cnt++;
                    end
                    m_out = (m_cnt < m_div / 2);
                end
            end else if (!lo) begin
                int p;
                m_hold = 0;
                m_div  = int'(div_sel) + 1;
                p      = int'(phase_sel);
                if (p >= m_div) p = m_div - 1;
                m_cnt  = p;
                m_out  = (m_cnt < m_div / 2);
            end else begin
                m_out = 0;
            end
            m_prev = lo;
        end
        #2;
        check(rst_n ? (passing() ? 1'b1 : m_out) : 1'b0);
    end

    always @(negedge clk) begin
        if (!rst_n) m_neg = 0;
        else        m_neg = !sync_n;
        #2;
        check(rst_n ? (passing() ? 1'b0 : m_out) : 1'b0);
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: reset holds output low, bypass included
        cur_req = "R1";
        bypass = 1'b1;
        cyc(2);
        bypass = 1'b0;
        div_sel = 5'd3;
        cyc(2);
        rst_n = 1'b1;
        // R4: even ratio 4
        cur_req = "R4";
        cyc(20);
        // R9: change mid-period, takes effect at the boundary
        cur_req = "R9";
        div_sel = 5'd4;
        cyc(4);
        // R4: odd ratio 5
        cur_req = "R4";
        cyc(20);
        // R3: largest ratio, then field zero
        cur_req = "R3";
        div_sel = 5'd31;
        cyc(80);
        div_sel = 5'd0;
        cyc(40);
        // R2: bypass over a divided setting
        cur_req = "R2";
        div_sel = 5'd5;
        cyc(15);
        bypass = 1'b1;
        cyc(10);
        bypass = 1'b0;
        cyc(15);
        // R5: one-cycle low pulse, rising-falling-rising not all low
        cur_req = "R5";
        sync_n = 1'b0;
        cyc(1);
        sync_n = 1'b1;
        cyc(10);
        // R5: falling-rising-falling low pulse, ignored
        @(negedge clk); #3; sync_n = 1'b0;
        @(negedge clk); #3; sync_n = 1'b1;
        cyc(10);
        // R5: falling-aligned pulse long enough to qualify
        @(negedge clk); #3; sync_n = 1'b0;
        @(negedge clk);
        @(negedge clk); #3; sync_n = 1'b1;
        cyc(12);
        // R6 and R7: hold, then release with phase 2 at ratio 6
        cur_req = "R6";
        div_sel = 5'd5;
        phase_sel = 5'd2;
        sync_n = 1'b0;
        cyc(6);
        cur_req = "R7";
        sync_n = 1'b1;
        cyc(20);
        // R7: odd ratio 7 with phase 5
        div_sel = 5'd6;
        phase_sel = 5'd5;
        sync_n = 1'b0;
        cyc(3);
        sync_n = 1'b1;
        cyc(20);
        // R8: phase 9 beyond ratio 4, clamped to 3
        cur_req = "R8";
        div_sel = 5'd3;
        phase_sel = 5'd9;
        sync_n = 1'b0;
        cyc(4);
        sync_n = 1'b1;
        cyc(15);
        // R9: ratio change right after a period start
        cur_req = "R9";
        div_sel = 5'd7;
        cyc(2);
        div_sel = 5'd2;
        cyc(24);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule